// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a battery-backed static memory through supply loss and supply return. Two comparator flags reach it asynchronously: one says the main supply has dropped under the level where the memory must stop taking accesses, the other says it has dropped further, under the level where storage has to run from the battery. A third, synchronous flag from the host bus says a memory access is under way. From these the block drives three registered controls: a write-protect/chip-deselect line, a force that puts the memory data outputs into high impedance, and a battery-select line.

When the supply sags, protection is held off so that an access in flight can complete. The delay lasts no longer than a bounded window, and protection is forced at the end of it. When the supply falls further, the battery is switched in, but only if main power has been seen at least once since reset, so a fresh part never drains its cell. When the supply comes back, protection stays on for a long recovery interval that lets the host settle. A new dip during that interval sends the sequencer straight back to protection. Both intervals are parameters counted in clock cycles. The level flags pass through two-flop synchronizers.

Top module: `pfail_seq`

## Requirements
- R1: During and directly after reset, protect_o and hiz_o are 1 and batt_sel_o is 0.
- R2: With main power good and no access under way, a rise of vlow_dsel_i raises protect_o at the fourth clock edge after the change: two synchronizer stages, then one cycle in the deferral state, then protection.
- R3: If access_active_i is 1 when the supply drop is seen, protect_o stays 0 while the access lasts and rises at the first clock edge that samples access_active_i as 0.
- R4: If the access is still active WIN_CYC cycles after deferral began, protect_o is forced to 1 at that edge regardless of access_active_i.
- R5: After vlow_dsel_i falls while the block is protected, protect_o stays 1 for REC_CYC cycles counted from the edge where the synchronized fall is seen, and then returns to 0.
- R6: While protected, a 1 on vlow_sw_i selects the battery (batt_sel_o = 1, three edges after the change) only once the synchronized vlow_dsel_i has been observed at 0 at least once since reset. Before that, batt_sel_o stays 0.
- R7: When vlow_sw_i returns to 0, batt_sel_o falls three edges later and protect_o stays 1.
- R8: A rise of vlow_dsel_i during recovery returns the block to protection, and the next recovery counts the full REC_CYC cycles again.
- R9: hiz_o always equals protect_o. While protect_o is 1, the value of access_active_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vlow_dsel_i | input | 1 | Asynchronous: supply below the deselect threshold |
| vlow_sw_i | input | 1 | Asynchronous: supply below the battery switchover threshold |
| access_active_i | input | 1 | Synchronous: host memory access in progress |
| protect_o | output | 1 | Chip deselect and write protect, active high |
| hiz_o | output | 1 | Force memory data outputs to high impedance |
| batt_sel_o | output | 1 | Select the battery as the storage supply |

## Verification
A change on either level flag reaches the outputs at the third clock edge after it is driven: two synchronizer flops, then the state and output registers. Protection without an access in flight therefore lands one edge later, at the fourth. A drop of access_active_i acts at the very next edge. The end of the window and the end of recovery land exactly WIN_CYC and REC_CYC edges after the state is entered. The driver stamps every expectation with the absolute cycle it is due in, including the cycle just before each boundary, and the monitor compares at the falling edge of exactly that cycle.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL    = 3'd0,
    ST_PENDING   = 3'd1,
    ST_PROTECTED = 3'd2,
    ST_BATTERY   = 3'd3,
    ST_RECOVERY  = 3'd4
  } pfs_state_t;
endpackage

// File: rtl/level_sync.sv
// Two-stage synchronizer for a vector of asynchronous level flags.
module level_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/interval_timer.sv
// Counts cycles from a clear; done is high once LIMIT-1 cycles have passed.
module interval_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pfs_fsm.sv
// Power-down / power-up state sequencing with registered outputs.
module pfs_fsm
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       below_dsel,
  input  logic       below_sw,
  input  logic       access_active,
  input  logic       win_done,
  input  logic       rec_done,
  output pfs_state_t state_q,
  output logic       armed_q,
  output logic       protect_q,
  output logic       hiz_q,
  output logic       batt_q
);
  pfs_state_t nxt;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_NORMAL:    if (below_dsel) nxt = ST_PENDING;
      ST_PENDING:   if (below_sw || !access_active || win_done) nxt = ST_PROTECTED;
      ST_PROTECTED: begin
        if (below_sw && armed_q) nxt = ST_BATTERY;
        else if (!below_dsel)    nxt = ST_RECOVERY;
      end
      ST_BATTERY:   if (!below_sw) nxt = ST_PROTECTED;
      ST_RECOVERY: begin
        if (below_dsel)    nxt = ST_PROTECTED;
        else if (rec_done) nxt = ST_NORMAL;
      end
      default:      nxt = ST_PROTECTED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_PROTECTED;
      armed_q   <= 1'b0;
      protect_q <= 1'b1;
      hiz_q     <= 1'b1;
      batt_q    <= 1'b0;
    end else begin
      state_q   <= nxt;
      if (!below_dsel) armed_q <= 1'b1;
      protect_q <= !(nxt == ST_NORMAL || nxt == ST_PENDING);
      hiz_q     <= !(nxt == ST_NORMAL || nxt == ST_PENDING);
      batt_q    <= (nxt == ST_BATTERY);
    end
  end
endmodule

// File: rtl/pfail_seq.sv
module pfail_seq
  import pfs_pkg::*;
#(
  parameter int WIN_CYC = 10000,
  parameter int REC_CYC = 8000000
) (
  input  logic clk,
  input  logic rst,
  input  logic vlow_dsel_i,
  input  logic vlow_sw_i,
  input  logic access_active_i,
  output logic protect_o,
  output logic hiz_o,
  output logic batt_sel_o
);
  localparam int NFLAG = 2;

  logic [NFLAG-1:0] flags_s;
  logic             dsel_s;
  logic             sw_s;
  logic             win_done;
  logic             rec_done;
  logic             armed_q;
  pfs_state_t       state_q;

  level_sync #(.W(NFLAG), .RST_VAL('1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({vlow_sw_i, vlow_dsel_i}),
    .sync_o  (flags_s)
  );
  assign dsel_s = flags_s[0];
  assign sw_s   = flags_s[1];

  interval_timer #(.LIMIT(WIN_CYC)) u_win (
    .clk  (clk),
    .rst  (rst),
    .clr  (state_q != ST_PENDING),
    .done (win_done)
  );

  interval_timer #(.LIMIT(REC_CYC)) u_rec (
    .clk  (clk),
    .rst  (rst),
    .clr  (state_q != ST_RECOVERY),
    .done (rec_done)
  );

  pfs_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .below_dsel    (dsel_s),
    .below_sw      (sw_s),
    .access_active (access_active_i),
    .win_done      (win_done),
    .rec_done      (rec_done),
    .state_q       (state_q),
    .armed_q       (armed_q),
    .protect_q     (protect_o),
    .hiz_q         (hiz_o),
    .batt_q        (batt_sel_o)
  );
endmodule

// File: rtl/pfail_seq_chk.sv
module pfail_seq_chk
  import pfs_pkg::*;
#(
  parameter int WIN_CYC = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       dsel_s,
  input logic       armed_q,
  input pfs_state_t state_q,
  input logic       protect_o,
  input logic       hiz_o,
  input logic       batt_sel_o
);
  localparam int PW = $clog2(WIN_CYC + 1) + 1;
  logic [PW-1:0] pend_cnt;

  always_ff @(posedge clk) begin
    if (rst || state_q != ST_PENDING) pend_cnt <= '0;
    else pend_cnt <= pend_cnt + 1'b1;
  end

  // R9
  hiz_match_chk: assert property (@(posedge clk) disable iff (rst)
    hiz_o == protect_o);

  // R6
  batt_needs_prot_chk: assert property (@(posedge clk) disable iff (rst)
    batt_sel_o |-> protect_o);

  // R6
  batt_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    batt_sel_o |-> armed_q);

  // R7
  batt_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(batt_sel_o) |-> protect_o);

  // R4
  window_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PENDING) |-> (pend_cnt < PW'(WIN_CYC)));

  // R8
  redip_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RECOVERY && dsel_s) |=> (state_q == ST_PROTECTED && protect_o));
endmodule

bind pfail_seq pfail_seq_chk #(.WIN_CYC(WIN_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dsel_s     (dsel_s),
  .armed_q    (armed_q),
  .state_q    (state_q),
  .protect_o  (protect_o),
  .hiz_o      (hiz_o),
  .batt_sel_o (batt_sel_o)
);

// File: tb/tb_pfail_seq.sv
`timescale 1ns/1ps
module tb_pfail_seq;
  localparam int WIN = 8;
  localparam int REC = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dsel = 1'b1, sw = 1'b1, acc = 1'b0;
  logic prot, hiz, batt;
  int   cyc = 0;
  int   checks = 0, fails = 0;
  bit   finished = 1'b0;

  typedef struct {int due; bit p; bit b; string req;} exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pfail_seq #(.WIN_CYC(WIN), .REC_CYC(REC)) dut (
    .clk(clk), .rst(rst), .vlow_dsel_i(dsel), .vlow_sw_i(sw),
    .access_active_i(acc), .protect_o(prot), .hiz_o(hiz), .batt_sel_o(batt)
  );

  task automatic expect_at(input int d, input bit p, input bit b, input string r);
    exp_t e;
    e.due = d; e.p = p; e.b = b; e.req = r;
    q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares due expectations at the falling edge.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.due != cyc || prot !== e.p || hiz !== e.p || batt !== e.b) begin
        fails++;
        $display("FAIL %s cyc=%0d: prot=%0b hiz=%0b batt=%0b expected prot=%0b hiz=%0b batt=%0b",
                 e.req, cyc, prot, hiz, batt, e.p, e.p, e.b);
      end
    end
  end

  task automatic finish_run();
    if (q.size() != 0) begin
      fails++;
      $display("FAIL pending expectations=%0d left unchecked", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c;
    expect_at(2, 1'b1, 1'b0, "R1");
    wait_cyc(3);
    rst = 1'b0;
    c = cyc;
    // R6: never powered, so no battery even though below switchover
    expect_at(c + 5, 1'b1, 1'b0, "R6 unarmed");
    wait_cyc(8);

    // First power-up: recovery then normal (R5)
    c = cyc; dsel = 1'b0; sw = 1'b0;
    expect_at(c + 34, 1'b1, 1'b0, "R5 hold");
    expect_at(c + 35, 1'b0, 1'b0, "R5 release");
    wait_cyc(40);

    // R2: fail with no access in flight
    c = cyc; dsel = 1'b1;
    expect_at(c + 3, 1'b0, 1'b0, "R2 deferral cycle");
    expect_at(c + 4, 1'b1, 1'b0, "R2 protect");
    wait_cyc(8);

    // R8: dip during recovery restarts the count
    c = cyc; dsel = 1'b0;
    wait_cyc(10);
    dsel = 1'b1;
    expect_at(c + 13, 1'b1, 1'b0, "R8 back to protect");
    wait_cyc(10);
    dsel = 1'b0;
    expect_at(c + 54, 1'b1, 1'b0, "R8 full recount hold");
    expect_at(c + 55, 1'b0, 1'b0, "R8 release");
    wait_cyc(40);

    // R3: access in flight defers protection
    c = cyc; acc = 1'b1; dsel = 1'b1;
    wait_cyc(6);
    expect_at(c + 6, 1'b0, 1'b0, "R3 deferred");
    acc = 1'b0;
    expect_at(c + 7, 1'b1, 1'b0, "R3 protect after access");
    wait_cyc(4);
    dsel = 1'b0;
    wait_cyc(40);

    // R4: access never ends, window forces protection
    c = cyc; acc = 1'b1; dsel = 1'b1;
    expect_at(c + 10, 1'b0, 1'b0, "R4 window open");
    expect_at(c + 11, 1'b1, 1'b0, "R4 forced");
    wait_cyc(14);

    // R9: access toggles while protected have no effect
    acc = 1'b0;
    c = cyc;
    expect_at(c + 2, 1'b1, 1'b0, "R9 access ignored");
    wait_cyc(3);
    acc = 1'b1;
    expect_at(c + 5, 1'b1, 1'b0, "R9 access ignored");
    wait_cyc(2);

    // R6: armed now, battery selected
    c = cyc; sw = 1'b1;
    expect_at(c + 2, 1'b1, 1'b0, "R6 sync latency");
    expect_at(c + 3, 1'b1, 1'b1, "R6 battery");
    wait_cyc(10);

    // R7: supply above switchover, battery released, still protected
    c = cyc; sw = 1'b0;
    expect_at(c + 3, 1'b1, 1'b0, "R7 release");
    wait_cyc(6);
    acc = 1'b0; dsel = 1'b0;
    c = cyc;
    expect_at(c + 35, 1'b0, 1'b0, "R5 resume");
    wait_cyc(40);

    finished = 1'b1;
    finish_run();
  end
endmodule